// File: doc/BRIEF.md
# Memory Access Latency Sequencer

This block stands between an execution unit and a two-level cache (a combined tag and data cache backed by a translation map cache). It does not hold any storage. The lookup results come in on hit inputs, and a slow backing path reports its end through a done handshake. From these the block works out how long a load or a store keeps the pipeline waiting. It raises a stall for the wait, gives one completion pulse, and asks for one interlock bubble when a loaded value is needed by the very next operation. The execution unit has no forwarding path, so the bubble is needed even when that next operation only stores the value.

The sequencer accepts a new access only while it is idle, or in the completion cycle of an access that needs no bubble. A request that arrives at any other time is dropped and reported on an error output. The miss penalty depends on whether the access is a read or a write, and on the level at which the lookup first hits.

Top module: `mem_latency_seq`

## Requirements
- R1: A read or a write with `tag_hit` and `data_hit` both 1 at acceptance raises `done` in the cycle after the request, and `stall` stays 0.
- R2: A read with `tag_hit`=1 and `data_hit`=0 takes 7 cycles. `stall` is high for cycles 1 to 6 after the request, and `done` is high in cycle 7.
- R3: A write with `tag_hit`=1 and `data_hit`=0 takes 10 cycles. `stall` covers cycles 1 to 9, and `done` is high in cycle 10.
- R4: With `tag_hit`=0 and `map_hit`=1, a read takes 10 cycles and a write takes 13 cycles, with the same stall and done shape as R2. `data_hit` has no effect when `tag_hit` is 0.
- R5: With `tag_hit`=0 and `map_hit`=0, `stall` holds until `slow_done` is seen high. `done` is high in the cycle after that.
- R6: A read accepted with `use_next`=1 raises `bubble` for exactly one cycle, in the cycle after `done`. A write ignores `use_next`.
- R7: `stall` and `done` are never high together. Each accepted access produces exactly one `done` cycle.
- R8: A request made while the sequencer is busy (in a stall cycle, a bubble cycle, or the completion cycle of an access that owes a bubble) raises `busy_err` in that same cycle. Such a request does not change the timing of the access in progress.
- R9: The hit inputs and `req_write` are sampled only in the cycle `req` is accepted. Later changes to them do not alter the latency.
- R10: While `rst_n` is 0 and after its release, `stall`, `done`, `bubble` and `busy_err` are 0 until a request arrives.
- R11: A request in the completion cycle of an access with no bubble owed is accepted, so hits can be issued back to back, one every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = store, 0 = load |
| use_next | input | 1 | Next operation consumes the loaded value |
| tag_hit | input | 1 | Address tag present in the local cache |
| data_hit | input | 1 | Data present in the local cache |
| map_hit | input | 1 | Translation present in the map cache |
| slow_done | input | 1 | Backing path finished a map-miss access |
| stall | output | 1 | Execution unit must hold |
| done | output | 1 | One-cycle completion pulse |
| bubble | output | 1 | Load-use interlock cycle |
| busy_err | output | 1 | Request arrived while busy and was dropped |

## Verification
Count the request cycle as cycle 0. For an access of N total cycles, `done` is due in cycle N, and `stall` is due in cycles 1 to N-1. A bubble is due in cycle N+1. `busy_err` is combinational and is due in the same cycle as the offending request. For a map miss, N is one more than the cycle in which `slow_done` is driven high.

The bench drives its inputs on the falling edge and samples shortly after it. It counts cycles from the request until `done` appears, and compares that count and the number of stall cycles with the figures above. During the wait it inverts the hit inputs, so the measured latency also shows that those inputs were sampled only at acceptance.

// File: rtl/mem_latency_seq.sv
module mem_latency_seq #(
  parameter int RD_LINE_MISS = 7,
  parameter int WR_LINE_MISS = 10,
  parameter int RD_MAP_HIT   = 10,
  parameter int WR_MAP_HIT   = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic req_write,
  input  logic use_next,
  input  logic tag_hit,
  input  logic data_hit,
  input  logic map_hit,
  input  logic slow_done,
  output logic stall,
  output logic done,
  output logic bubble,
  output logic busy_err
);
  localparam int MAX_RD = (RD_LINE_MISS > RD_MAP_HIT) ? RD_LINE_MISS : RD_MAP_HIT;
  localparam int MAX_WR = (WR_LINE_MISS > WR_MAP_HIT) ? WR_LINE_MISS : WR_MAP_HIT;
  localparam int MAX_LAT = (MAX_RD > MAX_WR) ? MAX_RD : MAX_WR;
  localparam int CW = $clog2(MAX_LAT + 1);

  typedef enum logic [2:0] {S_IDLE, S_COUNT, S_EXT, S_FIN, S_BUB} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] load_val;
  logic          bub_pend;
  logic          ready;
  logic          take;
  logic          full_hit;
  logic          walk;

  assign ready    = (state == S_IDLE) || (state == S_FIN && !bub_pend);
  assign take     = req && ready;
  assign full_hit = tag_hit && data_hit;
  assign walk     = !tag_hit && !map_hit;

  always_comb begin
    if (tag_hit)
      load_val = req_write ? CW'(WR_LINE_MISS - 2) : CW'(RD_LINE_MISS - 2);
    else
      load_val = req_write ? CW'(WR_MAP_HIT - 2) : CW'(RD_MAP_HIT - 2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      bub_pend <= 1'b0;
    end else if (take) begin
      bub_pend <= !req_write && use_next;
      cnt      <= load_val;
      if (full_hit)  state <= S_FIN;
      else if (walk) state <= S_EXT;
      else           state <= S_COUNT;
    end else begin
      case (state)
        S_COUNT: if (cnt == '0) state <= S_FIN;
                 else cnt <= cnt - 1'b1;
        S_EXT:   if (slow_done) state <= S_FIN;
        S_FIN:   begin
                   state    <= bub_pend ? S_BUB : S_IDLE;
                   bub_pend <= 1'b0;
                 end
        S_BUB:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign stall    = (state == S_COUNT) || (state == S_EXT);
  assign done     = (state == S_FIN);
  assign bubble   = (state == S_BUB);
  assign busy_err = req && !ready;

  a_r1_hit_next: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !busy_err && tag_hit && data_hit) |=> (done && !stall));

  a_r5_slow_end: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && slow_done && !tag_hit && state == S_EXT) |=> done);

  a_r6_bubble_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |-> $past(done));

  a_r6_bubble_single: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |=> !bubble);

  a_r7_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(stall && done));

  a_r8_err_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_err |-> (stall || bubble || done));

  a_r8_err_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_err && stall) |=> (stall || done));

endmodule

// File: tb/tb_mem_latency_seq.sv
module tb_mem_latency_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, req_write = 1'b0, use_next = 1'b0;
  logic tag_hit = 1'b0, data_hit = 1'b0, map_hit = 1'b0, slow_done = 1'b0;
  logic stall, done, bubble, busy_err;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_latency_seq dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
    .use_next(use_next), .tag_hit(tag_hit), .data_hit(data_hit),
    .map_hit(map_hit), .slow_done(slow_done),
    .stall(stall), .done(done), .bubble(bubble), .busy_err(busy_err)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic run_acc(input string rq, input bit wr, input bit t, input bit d,
                         input bit m, input bit u, input int exp_n, input int ext_at);
    int cyc;
    int stalls;
    @(negedge clk);
    req = 1'b1; req_write = wr; tag_hit = t; data_hit = d; map_hit = m; use_next = u;
    #1 chk(busy_err == 1'b0, rq, busy_err, 0);
    @(negedge clk);
    req = 1'b0; req_write = ~wr; tag_hit = ~t; data_hit = ~d; map_hit = ~m; use_next = ~u;
    cyc = 1; stalls = 0;
    while (cyc < 400) begin
      slow_done = (ext_at != 0 && cyc == ext_at);
      #1;
      if (done) break;
      if (stall) stalls++;
      @(negedge clk);
      cyc++;
    end
    slow_done = 1'b0;
    chk(cyc == exp_n, {rq, " latency"}, cyc, exp_n);
    chk(stalls == exp_n - 1, {rq, " stall cycles"}, stalls, exp_n - 1);
    chk(stall == 1'b0, {rq, " stall with done"}, stall, 0);
    @(negedge clk);
    #1 chk(bubble == (u && !wr), {rq, " bubble"}, bubble, int'(u && !wr));
    chk(done == 1'b0, {rq, " single done"}, done, 0);
    if (bubble) begin
      @(negedge clk);
      #1 chk(bubble == 1'b0, {rq, " bubble one cycle"}, bubble, 0);
    end
  endtask

  task automatic busy_case();
    int cyc;
    @(negedge clk);
    req = 1'b1; req_write = 1'b0; tag_hit = 1'b1; data_hit = 1'b0; map_hit = 1'b1; use_next = 1'b0;
    @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    req = 1'b1; tag_hit = 1'b1; data_hit = 1'b1;
    #1 chk(busy_err == 1'b1, "R8 err while stalled", busy_err, 1);
    @(negedge clk);
    req = 1'b0;
    cyc = 3;
    while (cyc < 50) begin
      #1;
      if (done) break;
      @(negedge clk);
      cyc++;
    end
    chk(cyc == 7, "R8 timing kept", cyc, 7);
  endtask

  task automatic back_to_back();
    @(negedge clk);
    req = 1'b1; req_write = 1'b0; tag_hit = 1'b1; data_hit = 1'b1; map_hit = 1'b1; use_next = 1'b0;
    @(negedge clk);
    req_write = 1'b1;
    #1 chk(done == 1'b1, "R11 first done", done, 1);
    chk(busy_err == 1'b0, "R11 accept in done cycle", busy_err, 0);
    @(negedge clk);
    req_write = 1'b0; use_next = 1'b1;
    #1 chk(done == 1'b1, "R11 second done", done, 1);
    @(negedge clk);
    use_next = 1'b0;
    #1 chk(done == 1'b1 && busy_err == 1'b1, "R8 err when bubble owed", busy_err, 1);
    @(negedge clk);
    req = 1'b0;
    #1 chk(bubble == 1'b1 && done == 1'b0, "R6 bubble after back-to-back", bubble, 1);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 chk({stall, done, bubble, busy_err} == 4'b0, "R10 in reset", int'({stall, done, bubble, busy_err}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1 chk({stall, done, bubble, busy_err} == 4'b0, "R10 after reset", int'({stall, done, bubble, busy_err}), 0);
    run_acc("R1 read hit",          1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1, 0);
    run_acc("R1 write hit",         1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1, 0);
    run_acc("R2 read line miss",    1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 7, 0);
    run_acc("R3 write line miss",   1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 10, 0);
    run_acc("R4 read map hit",      1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 10, 0);
    run_acc("R4 write map hit",     1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 13, 0);
    run_acc("R5 read map miss",     1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 41, 40);
    run_acc("R5 write map miss",    1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4, 3);
    run_acc("R6 read hit use",      1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1, 0);
    run_acc("R6 read miss use",     1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 7, 0);
    run_acc("R6 write ignores use", 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 10, 0);
    run_acc("R9 R7 map read",       1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 10, 0);
    busy_case();
    back_to_back();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule